// File: doc/BRIEF.md
# Serial Bus SCL Stall Guard

This block sits next to a 2-wire bus slave and watches the clock line while a transfer is in progress. Whenever SCL stays at one level for too long between two transitions, the block aborts the transfer. The slave's protocol logic reacts to the abort by letting go of SDA. This keeps a stuck master, or a clock line held low, from leaving the slave driving SDA low in the middle of a read.

The inputs are an SCL level that has already been synchronized, one-cycle START and STOP indications from the slave's condition detector, and an enable bit that comes from a configuration register. Between a START and a STOP, a counter counts system clock cycles and returns to zero on every rising or falling SCL transition. If the counter reaches the threshold, the block sends a one-cycle abort pulse. It then raises a blocked flag, which tells the slave to ignore the bus until a new START arrives. The threshold in cycles is calculated from the system clock frequency and the timeout length, and it is rounded up so that the real time can never be shorter than the timeout. With the default settings this is 20 ms.

Top module: `scl_stall_guard`

## Requirements
- R1: After reset, `abort_pulse` and `bus_blocked` are both low.
- R2: The threshold is LIMIT = ceil(CLK_HZ * TIMEOUT_US / 1,000,000) cycles. If SCL holds its level for LIMIT clock cycles counted from the cycle in which a START or the most recent SCL transition was registered, `abort_pulse` is high in cycle LIMIT after that registration.
- R3: A rising SCL transition and a falling SCL transition both restart the count. A transfer whose SCL transitions are never more than LIMIT-1 cycles apart never aborts.
- R4: `abort_pulse` stays high for exactly one cycle, and `bus_blocked` rises in that same cycle.
- R5: While blocked, SCL activity and STOP indications leave `bus_blocked` high and cause no further abort.
- R6: A START clears `bus_blocked` one cycle later and starts a fresh count from zero. This also holds for a repeated START in the middle of a transfer.
- R7: Outside a transfer (before the first START, or after a STOP) no abort happens, however long SCL is idle.
- R8: While `timeout_en` is low the counter is held at zero and no abort can occur. When the enable returns, counting starts again from zero, so the abort comes LIMIT cycles after the first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timeout_en | input | 1 | Timeout enable from the configuration register |
| scl_lvl | input | 1 | Synchronized SCL level |
| bus_start | input | 1 | One-cycle START (or repeated START) indication |
| bus_stop | input | 1 | One-cycle STOP indication |
| abort_pulse | output | 1 | One-cycle request to end the current transfer |
| bus_blocked | output | 1 | High from the abort until the next START |

## Verification
The bench sweeps the spacing between SCL transitions from one cycle up to two cycles past the threshold. It uses a clock and timeout that give a fractional threshold, so a design that rounds down or is off by one aborts one gap too early or reports the abort in the wrong cycle. It also checks that a design counting only rising edges is caught: such a design aborts on gaps that alternate rising and falling transitions. A design that clears the blocked flag on STOP, or that keeps counting after STOP, produces an unexpected second abort. The bench also drops the enable in the middle of a count. A design that only pauses the counter during this time, instead of clearing it, aborts too soon after the enable returns.

// File: rtl/scl_stall_guard.sv
module scl_stall_guard #(
  parameter longint unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned     TIMEOUT_US = 20_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic timeout_en,
  input  logic scl_lvl,
  input  logic bus_start,
  input  logic bus_stop,
  output logic abort_pulse,
  output logic bus_blocked
);

  localparam longint unsigned LIMIT_RAW =
    (CLK_HZ * longint'(TIMEOUT_US) + 64'd999_999) / 64'd1_000_000;
  localparam longint unsigned LIMIT = (LIMIT_RAW < 2) ? 64'd2 : LIMIT_RAW;
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic          scl_q;
  logic          in_xfer;
  logic [CW-1:0] gap_cnt;
  logic          scl_edge;
  logic          watching;
  logic          fire;

  assign scl_edge = scl_lvl ^ scl_q;
  assign watching = in_xfer & ~bus_blocked & timeout_en & ~bus_start & ~bus_stop;
  assign fire     = watching & ~scl_edge & (gap_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q       <= 1'b1;
      abort_pulse <= 1'b0;
    end else begin
      scl_q       <= scl_lvl;
      abort_pulse <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_xfer     <= 1'b0;
      bus_blocked <= 1'b0;
      gap_cnt     <= '0;
    end else if (bus_start) begin
      in_xfer     <= 1'b1;
      bus_blocked <= 1'b0;
      gap_cnt     <= '0;
    end else if (bus_stop) begin
      in_xfer <= 1'b0;
      gap_cnt <= '0;
    end else if (fire) begin
      in_xfer     <= 1'b0;
      bus_blocked <= 1'b1;
      gap_cnt     <= '0;
    end else if (watching && !scl_edge) begin
      gap_cnt <= gap_cnt + 1'b1;
    end else begin
      gap_cnt <= '0;
    end
  end

endmodule

module scl_stall_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic timeout_en,
  input logic scl_lvl,
  input logic bus_start,
  input logic bus_stop,
  input logic abort_pulse,
  input logic bus_blocked
);

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);

  a_r4_block_with_abort: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_blocked) |-> abort_pulse);

  a_r4_abort_sets_block: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |-> bus_blocked);

  a_r5_block_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_blocked && !bus_start) |=> bus_blocked);

  a_r5_no_abort_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    bus_blocked |=> !abort_pulse);

  a_r6_start_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> (!bus_blocked && !abort_pulse));

  a_r7_stop_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !abort_pulse);

  a_r8_disabled_no_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !timeout_en |=> !abort_pulse);

endmodule

bind scl_stall_guard scl_stall_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .timeout_en(timeout_en), .scl_lvl(scl_lvl),
  .bus_start(bus_start), .bus_stop(bus_stop),
  .abort_pulse(abort_pulse), .bus_blocked(bus_blocked)
);

// File: tb/tb_scl_stall_guard.sv
module tb_scl_stall_guard;

  localparam longint unsigned HZ = 2_500_000;
  localparam int unsigned     US = 7;
  localparam int LIMIT = int'((HZ * US + 999_999) / 1_000_000);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, scl = 1'b1, st = 1'b0, sp = 1'b0;
  logic abort_pulse, bus_blocked;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  scl_stall_guard #(.CLK_HZ(HZ), .TIMEOUT_US(US)) dut (
    .clk(clk), .rst_n(rst_n), .timeout_en(en), .scl_lvl(scl),
    .bus_start(st), .bus_stop(sp),
    .abort_pulse(abort_pulse), .bus_blocked(bus_blocked)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) st = 1'b1;
    @(negedge clk) st = 1'b0;
  endtask

  task automatic pulse_stop();
    @(negedge clk) sp = 1'b1;
    @(negedge clk) sp = 1'b0;
  endtask

  // waits n cycles, returns abort count and cycle of first abort (0 if none)
  task automatic watch(input int n, inout int cyc, inout int n_ab, inout int first);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      if (abort_pulse) begin
        n_ab++;
        if (first == 0) first = cyc;
      end
    end
  endtask

  initial begin
    int cyc, n_ab, first;
    repeat (3) @(negedge clk);
    chk(abort_pulse == 1'b0, "R1 abort after reset", abort_pulse, 0);
    chk(bus_blocked == 1'b0, "R1 blocked after reset", bus_blocked, 0);
    rst_n = 1'b1;

    // R7: idle before any START
    cyc = 0; n_ab = 0; first = 0;
    watch(3 * LIMIT, cyc, n_ab, first);
    chk(n_ab == 0, "R7 no abort before START", n_ab, 0);

    // R2/R3: sweep transition spacing
    for (int k = 1; k <= LIMIT + 2; k++) begin
      pulse_start();
      cyc = 0; n_ab = 0; first = 0;
      for (int j = 0; j < 3; j++) begin
        watch(k, cyc, n_ab, first);
        scl = ~scl;
      end
      if (k < LIMIT) begin
        chk(n_ab == 0, "R3 gap below limit", n_ab, 0);
        chk(bus_blocked == 1'b0, "R3 not blocked", bus_blocked, 0);
      end else begin
        chk(n_ab == 1, "R5 one abort only", n_ab, 1);
        chk(first == LIMIT, "R2 abort cycle", first, LIMIT);
        chk(bus_blocked == 1'b1, "R4 blocked after abort", bus_blocked, 1);
      end
      pulse_stop();
      if (scl != 1'b1) begin
        @(negedge clk) scl = 1'b1;
      end
    end

    // R4: pulse width
    pulse_start();
    cyc = 0; n_ab = 0; first = 0;
    watch(LIMIT, cyc, n_ab, first);
    chk(abort_pulse && bus_blocked, "R4 abort with blocked", {abort_pulse, bus_blocked}, 3);
    @(negedge clk);
    chk(abort_pulse == 1'b0, "R4 single cycle", abort_pulse, 0);

    // R5: stop and SCL activity while blocked
    pulse_stop();
    cyc = 0; n_ab = 0; first = 0;
    for (int j = 0; j < 4; j++) begin
      watch(LIMIT + 3, cyc, n_ab, first);
      scl = ~scl;
    end
    chk(bus_blocked == 1'b1, "R5 stays blocked after STOP", bus_blocked, 1);
    chk(n_ab == 0, "R5 no abort while blocked", n_ab, 0);
    @(negedge clk) scl = 1'b1;

    // R6: START unblocks and count starts fresh
    pulse_start();
    chk(bus_blocked == 1'b0, "R6 START clears blocked", bus_blocked, 0);
    cyc = 0; n_ab = 0; first = 0;
    watch(LIMIT - 3, cyc, n_ab, first);
    pulse_start();
    cyc = 0; n_ab = 0; first = 0;
    watch(LIMIT + 2, cyc, n_ab, first);
    chk(first == LIMIT, "R6 repeated START restarts count", first, LIMIT);
    pulse_start();

    // R7: after STOP, no counting
    cyc = 0; n_ab = 0; first = 0;
    watch(LIMIT - 2, cyc, n_ab, first);
    pulse_stop();
    watch(3 * LIMIT, cyc, n_ab, first);
    chk(n_ab == 0, "R7 no abort after STOP", n_ab, 0);

    // R8: disable mid count, re-enable restarts from zero
    pulse_start();
    cyc = 0; n_ab = 0; first = 0;
    watch(LIMIT - 2, cyc, n_ab, first);
    en = 1'b0;
    watch(3 * LIMIT, cyc, n_ab, first);
    chk(n_ab == 0, "R8 no abort while disabled", n_ab, 0);
    en = 1'b1;
    cyc = 0; n_ab = 0; first = 0;
    watch(LIMIT + 2, cyc, n_ab, first);
    chk(first == LIMIT, "R8 count restarts on enable", first, LIMIT);

    // R8: disable exactly on the firing cycle
    pulse_start();
    cyc = 0; n_ab = 0; first = 0;
    watch(LIMIT - 1, cyc, n_ab, first);
    en = 1'b0;
    watch(4, cyc, n_ab, first);
    chk(n_ab == 0, "R8 disable suppresses abort", n_ab, 0);
    chk(bus_blocked == 1'b0, "R8 not blocked", bus_blocked, 0);
    en = 1'b1;
    pulse_stop();

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule